// File: doc/BRIEF.md
# Atomic Memory Operation Unit

This block carries out one indivisible read-modify-write on a shared memory port for the atomic store instructions of a register-based virtual machine. On a start pulse it takes the operand size, the base register value, a signed 16-bit displacement, the source register value, the R0 value and a 32-bit operation immediate. It then runs a fixed sequence: it takes the memory lock, reads the addressed location, computes the new value, writes it back when the operation requires a write, drops the lock, and pulses `done`.

The immediate selects the operation. Four arithmetic and logic updates are available, each with or without a fetch of the old value. Exchange and compare-exchange always fetch. The unit does not write registers itself. Together with `done` it reports the old memory value and whether that value goes to the source register or to R0. Operand sizes or immediates it does not support raise `err` and touch no memory.

Top module: `amo_unit`

## Requirements
- R1: `op_size` codes are 0 = 32-bit, 1 = 16-bit, 2 = 8-bit, 3 = 64-bit. Only 0 and 3 are executed. Codes 1 and 2 give `done` with `err` = 1, and no memory request is issued.
- R2: The memory address `mem_addr` equals `base_val` plus `offset` sign-extended to 64 bits.
- R3: The low byte of `op_imm` selects the update. Its bits [7:1] are 0x00 for add, 0x40 for or, 0x50 for and and 0xa0 for xor. The value written to memory is the old value combined with `src_val`.
- R4: `op_imm` bit 0 is the fetch flag. When it is set for an update, `done` comes with `wb_en` = 1, `wb_to_r0` = 0 and `old_val` = the prior memory value. When it is clear, `wb_en` = 0.
- R5: Exchange (`op_imm` = 0xe1) writes `src_val` to memory and returns the prior value with `wb_en` = 1 and `wb_to_r0` = 0.
- R6: Compare-exchange (`op_imm` = 0xf1) writes `src_val` only when the prior memory value equals `r0_val`. On a mismatch no write request is issued.
- R7: Compare-exchange always ends with `wb_en` = 1, `wb_to_r0` = 1 and `old_val` = the prior memory value, whether or not the compare matched.
- R8: Any other immediate value gives `done` with `err` = 1 and no memory request. This covers 0xe0, 0xf0, a value outside the listed set, and any nonzero bit in [31:8].
- R9: `mem_req` is only high while `mem_lock` is high. The lock is held from the read through the write. The lock is released before `done`. A request that is not granted holds its address.
- R10: For 32-bit operations (`mem_dw` = 0) only the low 32 bits of `src_val`, `r0_val` and `mem_rdata` are used. `old_val` is zero-extended, and bits [63:32] of `mem_wdata` are 0.
- R11: `start` is ignored while an operation is in progress, including the cycle in which `done` is high.
- R12: `done` is a single-cycle pulse. After reset `done`, `mem_req` and `mem_lock` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation (sampled when idle) |
| op_size | input | 2 | Operand size code |
| base_val | input | 64 | Base register value |
| offset | input | 16 | Signed address displacement |
| src_val | input | 64 | Source register value |
| r0_val | input | 64 | R0 value (compare operand) |
| op_imm | input | 32 | Operation immediate |
| mem_req | output | 1 | Memory access request |
| mem_lock | output | 1 | Exclusive lock on the memory |
| mem_we | output | 1 | Request is a write |
| mem_dw | output | 1 | Access is 64-bit (else 32-bit) |
| mem_addr | output | 64 | Byte address |
| mem_wdata | output | 64 | Write data |
| mem_gnt | input | 1 | Request accepted this cycle |
| mem_rdata | input | 64 | Read data, valid with grant on a read |
| done | output | 1 | Operation finished (one-cycle pulse) |
| err | output | 1 | Operation rejected, valid with done |
| old_val | output | 64 | Prior memory value, valid with done |
| wb_en | output | 1 | Write old_val to a register |
| wb_to_r0 | output | 1 | Target is R0 (else the source register) |

## Verification
Completion and acceptance of a new operation can meet in one cycle, because a caller may present `start` while `done` is still high. The bench raises `start` in exactly the cycle in which `done` is observed. It then checks that no further memory request appears, that the write count stays at one, and that the memory holds the result of a single operation. A second overlap is a grant that arrives late while the lock is held. The bench delays the grant by several cycles and checks that the result is unchanged and that the address stayed stable.

// File: rtl/amo_pkg.sv
package amo_pkg;
  typedef enum logic [2:0] {
    AK_ADD, AK_OR, AK_AND, AK_XOR, AK_SWAP, AK_CAS
  } amo_kind_e;

  typedef enum logic [2:0] {
    S_IDLE, S_READ, S_CALC, S_WRITE, S_FREE, S_DONE
  } amo_state_e;

  localparam logic [1:0] SZ_WORD  = 2'd0;
  localparam logic [1:0] SZ_DWORD = 2'd3;

  localparam logic [6:0] OPC_ADD  = 7'h00;
  localparam logic [6:0] OPC_OR   = 7'h20;
  localparam logic [6:0] OPC_AND  = 7'h28;
  localparam logic [6:0] OPC_XOR  = 7'h50;
  localparam logic [6:0] OPC_SWAP = 7'h70;
  localparam logic [6:0] OPC_CAS  = 7'h78;
endpackage

// File: rtl/amo_decode.sv
module amo_decode
  import amo_pkg::*;
#(
  parameter int IMMW = 32
) (
  input  logic [IMMW-1:0] imm,
  input  logic [1:0]      size,
  output amo_kind_e       kind,
  output logic            fetch,
  output logic            dword,
  output logic            legal
);
  logic       upper_zero;
  logic       op_ok;
  logic       size_ok;
  logic [6:0] opc;

  assign upper_zero = (imm[IMMW-1:8] == '0);
  assign opc        = imm[7:1];
  assign fetch      = imm[0];
  assign size_ok    = (size == SZ_WORD) || (size == SZ_DWORD);
  assign dword      = (size == SZ_DWORD);

  always_comb begin
    kind  = AK_ADD;
    op_ok = 1'b1;
    unique case (opc)
      OPC_ADD:  kind = AK_ADD;
      OPC_OR:   kind = AK_OR;
      OPC_AND:  kind = AK_AND;
      OPC_XOR:  kind = AK_XOR;
      OPC_SWAP: begin kind = AK_SWAP; op_ok = imm[0]; end
      OPC_CAS:  begin kind = AK_CAS;  op_ok = imm[0]; end
      default:  op_ok = 1'b0;
    endcase
  end

  assign legal = upper_zero && op_ok && size_ok;
endmodule

// File: rtl/amo_alu.sv
module amo_alu
  import amo_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  amo_kind_e       kind,
  input  logic            dword,
  input  logic [XLEN-1:0] old_v,
  input  logic [XLEN-1:0] src_v,
  input  logic [XLEN-1:0] cmp_v,
  output logic [XLEN-1:0] new_v,
  output logic            do_write
);
  localparam int HALF = XLEN / 2;

  logic [XLEN-1:0] mask;
  logic [XLEN-1:0] s_m;
  logic [XLEN-1:0] c_m;
  logic [XLEN-1:0] o_m;
  logic [XLEN-1:0] raw;

  assign mask = dword ? '1 : {{(XLEN-HALF){1'b0}}, {HALF{1'b1}}};
  assign s_m  = src_v & mask;
  assign c_m  = cmp_v & mask;
  assign o_m  = old_v & mask;

  always_comb begin
    do_write = 1'b1;
    unique case (kind)
      AK_ADD:  raw = o_m + s_m;
      AK_OR:   raw = o_m | s_m;
      AK_AND:  raw = o_m & s_m;
      AK_XOR:  raw = o_m ^ s_m;
      AK_SWAP: raw = s_m;
      AK_CAS:  begin raw = s_m; do_write = (o_m == c_m); end
      default: raw = o_m;
    endcase
  end

  assign new_v = raw & mask;
endmodule

// File: rtl/amo_unit.sv
module amo_unit
  import amo_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int OFFW = 16,
  parameter int IMMW = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [1:0]      op_size,
  input  logic [XLEN-1:0] base_val,
  input  logic [OFFW-1:0] offset,
  input  logic [XLEN-1:0] src_val,
  input  logic [XLEN-1:0] r0_val,
  input  logic [IMMW-1:0] op_imm,
  output logic            mem_req,
  output logic            mem_lock,
  output logic            mem_we,
  output logic            mem_dw,
  output logic [XLEN-1:0] mem_addr,
  output logic [XLEN-1:0] mem_wdata,
  input  logic            mem_gnt,
  input  logic [XLEN-1:0] mem_rdata,
  output logic            done,
  output logic            err,
  output logic [XLEN-1:0] old_val,
  output logic            wb_en,
  output logic            wb_to_r0
);
  localparam int HALF = XLEN / 2;

  amo_state_e      st_q, st_d;
  amo_kind_e       dec_kind, kind_q;
  logic            dec_fetch, dec_dw, dec_legal;
  logic            fetch_q, dw_q, err_q, wr_q;
  logic [XLEN-1:0] addr_q, src_q, r0_q, old_q, new_q;
  logic [XLEN-1:0] alu_new;
  logic            alu_wr;
  logic [XLEN-1:0] rd_ext;
  logic            cap_en, rd_en, calc_en;

  amo_decode #(.IMMW(IMMW)) u_dec (
    .imm   (op_imm),
    .size  (op_size),
    .kind  (dec_kind),
    .fetch (dec_fetch),
    .dword (dec_dw),
    .legal (dec_legal)
  );

  amo_alu #(.XLEN(XLEN)) u_alu (
    .kind     (kind_q),
    .dword    (dw_q),
    .old_v    (old_q),
    .src_v    (src_q),
    .cmp_v    (r0_q),
    .new_v    (alu_new),
    .do_write (alu_wr)
  );

  assign rd_ext = dw_q ? mem_rdata : {{(XLEN-HALF){1'b0}}, mem_rdata[HALF-1:0]};

  // next-state and port control
  always_comb begin
    st_d     = st_q;
    cap_en   = 1'b0;
    rd_en    = 1'b0;
    calc_en  = 1'b0;
    mem_req  = 1'b0;
    mem_we   = 1'b0;
    mem_lock = 1'b0;
    unique case (st_q)
      S_IDLE: if (start) begin
        cap_en = 1'b1;
        st_d   = dec_legal ? S_READ : S_DONE;
      end
      S_READ: begin
        mem_lock = 1'b1;
        mem_req  = 1'b1;
        if (mem_gnt) begin
          rd_en = 1'b1;
          st_d  = S_CALC;
        end
      end
      S_CALC: begin
        mem_lock = 1'b1;
        calc_en  = 1'b1;
        st_d     = alu_wr ? S_WRITE : S_FREE;
      end
      S_WRITE: begin
        mem_lock = 1'b1;
        mem_req  = 1'b1;
        mem_we   = 1'b1;
        if (mem_gnt) st_d = S_FREE;
      end
      S_FREE:  st_d = S_DONE;
      S_DONE:  st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= S_IDLE;
    else        st_q <= st_d;
  end

  // operand capture
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      src_q   <= '0;
      r0_q    <= '0;
      kind_q  <= AK_ADD;
      fetch_q <= 1'b0;
      dw_q    <= 1'b0;
      err_q   <= 1'b0;
    end else if (cap_en) begin
      addr_q  <= base_val + {{(XLEN-OFFW){offset[OFFW-1]}}, offset};
      src_q   <= src_val;
      r0_q    <= r0_val;
      kind_q  <= dec_kind;
      fetch_q <= dec_fetch;
      dw_q    <= dec_dw;
      err_q   <= ~dec_legal;
    end
  end

  // old value: cleared at capture, loaded on read grant
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      old_q <= '0;
    else if (cap_en) old_q <= '0;
    else if (rd_en)  old_q <= rd_ext;
  end

  // computed value
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      new_q <= '0;
      wr_q  <= 1'b0;
    end else if (calc_en) begin
      new_q <= alu_new;
      wr_q  <= alu_wr;
    end
  end

  assign mem_addr  = addr_q;
  assign mem_dw    = dw_q;
  assign mem_wdata = new_q;
  assign done      = (st_q == S_DONE);
  assign err       = done & err_q;
  assign old_val   = old_q;
  assign wb_en     = done & ~err_q & fetch_q;
  assign wb_to_r0  = done & ~err_q & (kind_q == AK_CAS);

  logic unused_ok;
  assign unused_ok = wr_q;
endmodule

// File: rtl/amo_unit_chk.sv
module amo_unit_chk #(
  parameter int XLEN = 64
) (
  input logic            clk,
  input logic            rst_n,
  input logic            mem_req,
  input logic            mem_lock,
  input logic            mem_we,
  input logic            mem_gnt,
  input logic            mem_dw,
  input logic [XLEN-1:0] mem_addr,
  input logic [XLEN-1:0] mem_wdata,
  input logic            done,
  input logic            err
);
  localparam int HALF = XLEN / 2;

  a_r9_req_needs_lock: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_lock);

  a_r9_free_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!mem_lock && !mem_req));

  a_r9_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  a_r12_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r10_wdata_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && !mem_dw) |-> (mem_wdata[XLEN-1:HALF] == '0));

  a_r8_err_no_access: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err) |-> !$past(mem_req));
endmodule

bind amo_unit amo_unit_chk #(.XLEN(XLEN)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mem_req   (mem_req),
  .mem_lock  (mem_lock),
  .mem_we    (mem_we),
  .mem_gnt   (mem_gnt),
  .mem_dw    (mem_dw),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata),
  .done      (done),
  .err       (err)
);

// File: tb/amo_unit_tb.sv
module amo_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  op_size = 2'd3;
  logic [63:0] base_val = '0;
  logic [15:0] offset = '0;
  logic [63:0] src_val = '0;
  logic [63:0] r0_val = '0;
  logic [31:0] op_imm = '0;
  logic        mem_req, mem_lock, mem_we, mem_dw, mem_gnt;
  logic [63:0] mem_addr, mem_wdata, mem_rdata;
  logic        done, err, wb_en, wb_to_r0;
  logic [63:0] old_val;

  int vec_n = 0;
  int bad_n = 0;
  int gnt_delay = 0;
  int wait_cnt = 0;
  int wr_count = 0;
  int rd_count = 0;
  int cyc = 0;

  logic [63:0] mem_m [0:7];
  logic        r_err, r_wb, r_r0;
  logic [63:0] r_old;

  always #10 clk = ~clk;

  amo_unit u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op_size(op_size),
    .base_val(base_val), .offset(offset), .src_val(src_val), .r0_val(r0_val),
    .op_imm(op_imm), .mem_req(mem_req), .mem_lock(mem_lock), .mem_we(mem_we),
    .mem_dw(mem_dw), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_gnt(mem_gnt), .mem_rdata(mem_rdata), .done(done), .err(err),
    .old_val(old_val), .wb_en(wb_en), .wb_to_r0(wb_to_r0)
  );

  // memory model: 8 doublewords, addr[5:3] index, addr[2] selects 32-bit lane
  assign mem_gnt   = mem_req && (wait_cnt >= gnt_delay);
  assign mem_rdata = mem_dw ? mem_m[mem_addr[5:3]]
                   : (mem_addr[2] ? {32'h0, mem_m[mem_addr[5:3]][63:32]}
                                  : {32'h0, mem_m[mem_addr[5:3]][31:0]});

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mem_req && !mem_gnt) wait_cnt <= wait_cnt + 1;
    else                     wait_cnt <= 0;
    if (mem_req && mem_gnt) begin
      if (mem_we) begin
        wr_count <= wr_count + 1;
        if (mem_dw) mem_m[mem_addr[5:3]] <= mem_wdata;
        else if (mem_addr[2]) mem_m[mem_addr[5:3]][63:32] <= mem_wdata[31:0];
        else                  mem_m[mem_addr[5:3]][31:0]  <= mem_wdata[31:0];
      end else begin
        rd_count <= rd_count + 1;
      end
    end
  end

  initial begin
    #2_000_000;
    bad_n = bad_n + 1;
    $display("FAIL watchdog: run did not finish (act=hung exp=finished)");
    $display("== %0d vectors applied, %0d miscompares ==", vec_n, bad_n);
    $finish;
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    vec_n = vec_n + 1;
    if (act !== exp) begin
      bad_n = bad_n + 1;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic run_op(input logic [1:0] sz, input logic [63:0] b, input logic [15:0] off,
                        input logic [63:0] s, input logic [63:0] r0, input logic [31:0] imm);
    @(negedge clk);
    op_size = sz; base_val = b; offset = off; src_val = s; r0_val = r0; op_imm = imm;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 60; i++) begin
      if (done) break;
      @(negedge clk);
    end
    chk("R12 done seen", {63'h0, done}, 64'h1);
    r_err = err; r_wb = wb_en; r_r0 = wb_to_r0; r_old = old_val;
    @(negedge clk);
    chk("R12 done one cycle", {63'h0, done}, 64'h0);
  endtask

  task automatic t_reset;
    chk("R12 reset done", {63'h0, done}, 64'h0);
    chk("R12 reset req", {63'h0, mem_req}, 64'h0);
    chk("R12 reset lock", {63'h0, mem_lock}, 64'h0);
  endtask

  task automatic t_add64;
    mem_m[1] = 64'd100;
    run_op(2'd3, 64'h0, 16'h0008, 64'd5, 64'h0, 32'h00);
    chk("R3 add64 mem", mem_m[1], 64'd105);
    chk("R4 no fetch wb_en", {63'h0, r_wb}, 64'h0);
    chk("R2 add64 err", {63'h0, r_err}, 64'h0);
  endtask

  task automatic t_or32_fetch;
    mem_m[2] = 64'hFFFF_FFFF_0000_00F0;
    run_op(2'd0, 64'h10, 16'h0000, 64'hAAAA_AAAA_0000_000F, 64'h0, 32'h41);
    chk("R3 or32 mem", mem_m[2], 64'hFFFF_FFFF_0000_00FF);
    chk("R10 or32 old zext", r_old, 64'h0000_0000_0000_00F0);
    chk("R4 fetch wb_en", {63'h0, r_wb}, 64'h1);
    chk("R4 fetch target src", {63'h0, r_r0}, 64'h0);
  endtask

  task automatic t_and_negoff;
    mem_m[5] = 64'h1234_5678_9ABC_DEF0;
    run_op(2'd3, 64'h40, 16'hFFE8, 64'hFF00_FF00_FF00_FF00, 64'h0, 32'h51);
    chk("R2 negative offset and", mem_m[5], 64'h1200_5600_9A00_DE00);
    chk("R4 and fetch old", r_old, 64'h1234_5678_9ABC_DEF0);
  endtask

  task automatic t_xor32_hi;
    mem_m[3] = 64'h0000_00FF_1111_1111;
    run_op(2'd0, 64'h1C, 16'h0000, 64'h0000_0000_0000_000F, 64'h0, 32'hA0);
    chk("R10 xor32 upper lane", mem_m[3], 64'h0000_00F0_1111_1111);
    chk("R4 xor no fetch", {63'h0, r_wb}, 64'h0);
  endtask

  task automatic t_swap;
    mem_m[4] = 64'hDEAD_BEEF_0000_0001;
    run_op(2'd3, 64'h20, 16'h0000, 64'h0BAD_F00D_0000_0002, 64'h0, 32'hE1);
    chk("R5 swap mem", mem_m[4], 64'h0BAD_F00D_0000_0002);
    chk("R5 swap old", r_old, 64'hDEAD_BEEF_0000_0001);
    chk("R5 swap wb", {62'h0, r_wb, r_r0}, 64'h2);
  endtask

  task automatic t_cas;
    int w0;
    mem_m[6] = 64'h0000_0000_0000_0777;
    run_op(2'd3, 64'h30, 16'h0000, 64'h0000_0000_0000_0888, 64'h777, 32'hF1);
    chk("R6 cas match mem", mem_m[6], 64'h888);
    chk("R7 cas match wb", {62'h0, r_wb, r_r0}, 64'h3);
    chk("R7 cas match old", r_old, 64'h777);
    w0 = wr_count;
    run_op(2'd3, 64'h30, 16'h0000, 64'h999, 64'h777, 32'hF1);
    chk("R6 cas miss mem", mem_m[6], 64'h888);
    chk("R6 cas miss no write", w0, wr_count);
    chk("R7 cas miss old in r0", r_old, 64'h888);
    chk("R7 cas miss wb", {62'h0, r_wb, r_r0}, 64'h3);
    mem_m[7] = 64'hCCCC_CCCC_1234_5678;
    run_op(2'd0, 64'h38, 16'h0000, 64'h5555_5555_0000_0042, 64'hDEAD_0000_1234_5678, 32'hF1);
    chk("R10 cas32 low compare", mem_m[7], 64'hCCCC_CCCC_0000_0042);
    chk("R10 cas32 old zext", r_old, 64'h0000_0000_1234_5678);
  endtask

  task automatic t_errors;
    int r0c, w0c;
    logic [63:0] snap;
    snap = mem_m[1]; r0c = rd_count; w0c = wr_count;
    run_op(2'd1, 64'h0, 16'h0008, 64'd1, 64'h0, 32'h00);
    chk("R1 half size err", {63'h0, r_err}, 64'h1);
    run_op(2'd2, 64'h0, 16'h0008, 64'd1, 64'h0, 32'h00);
    chk("R1 byte size err", {63'h0, r_err}, 64'h1);
    run_op(2'd3, 64'h0, 16'h0008, 64'd1, 64'h0, 32'hE0);
    chk("R8 swap without fetch err", {63'h0, r_err}, 64'h1);
    run_op(2'd3, 64'h0, 16'h0008, 64'd1, 64'h0, 32'hF0);
    chk("R8 cas without fetch err", {63'h0, r_err}, 64'h1);
    run_op(2'd3, 64'h0, 16'h0008, 64'd1, 64'h0, 32'h100);
    chk("R8 upper imm bits err", {63'h0, r_err}, 64'h1);
    run_op(2'd3, 64'h0, 16'h0008, 64'd1, 64'h0, 32'h30);
    chk("R8 unlisted imm err", {63'h0, r_err}, 64'h1);
    chk("R8 err no wb", {63'h0, r_wb}, 64'h0);
    chk("R8 no reads", r0c, rd_count);
    chk("R8 no writes", w0c, wr_count);
    chk("R1 mem untouched", mem_m[1], snap);
  endtask

  task automatic t_slow_grant;
    mem_m[0] = 64'd40;
    gnt_delay = 3;
    run_op(2'd3, 64'h0, 16'h0000, 64'd2, 64'h0, 32'h01);
    gnt_delay = 0;
    chk("R9 slow grant mem", mem_m[0], 64'd42);
    chk("R9 slow grant old", r_old, 64'd40);
  endtask

  task automatic t_busy_start;
    int w0, rq0;
    mem_m[0] = 64'd10;
    w0 = wr_count;
    @(negedge clk);
    op_size = 2'd3; base_val = 64'h0; offset = 16'h0; src_val = 64'd1; op_imm = 32'h00;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    start = 1'b1; src_val = 64'd100;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 60; i++) begin
      if (done) break;
      @(negedge clk);
    end
    rq0 = rd_count;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (4) @(negedge clk);
    chk("R11 single op result", mem_m[0], 64'd11);
    chk("R11 one write", wr_count - w0, 1);
    chk("R11 start at done ignored", rd_count, rq0);
    chk("R11 no request after", {63'h0, mem_req}, 64'h0);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) mem_m[i] = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_add64();
    t_or32_fetch();
    t_and_negoff();
    t_xor32_hi();
    t_swap();
    t_cas();
    t_errors();
    t_slow_grant();
    t_busy_start();
    $display("== %0d vectors applied, %0d miscompares ==", vec_n, bad_n);
    $finish;
  end
endmodule